// File: doc/BRIEF.md
# Ethernet receive frame filter

This block sits behind the line decoder on the receive side of a 10 Mb/s Ethernet station. It takes a byte stream with a valid flag, a start-of-frame flag and carrier sense. It skips the preamble and locks onto the start frame delimiter. From the destination address through the frame check sequence, it compares the address with the programmed station address, counts the length and runs a CRC-32.

While the destination address still matches, each received byte goes to a buffer write port one cycle after it arrives. When carrier drops, the block issues a one-cycle end strobe. The strobe carries the byte count, the status flags and an accept bit. The buffer uses the accept bit to commit the frame or throw it away.

Top module: `rx_frame_filter`

## Requirements
- R1: After `sof_i` with carrier, preamble bytes 55h are skipped. The first D5h byte starts the frame, and no byte at or before it is written or counted.
- R2: If a byte other than 55h or D5h arrives before the delimiter, the frame is ignored. Nothing is written, no end strobe is issued, and the block waits for carrier to drop.
- R3: A frame byte is written on `wr_en_o`/`wr_data_o` one cycle after it arrives, as long as every address byte so far equals the station address. The first address byte on the wire is compared with `station_addr_i[47:40]`. After a mismatch, the rest of the frame is not written.
- R4: `len_o` reports the number of bytes from the destination address through the check sequence. It saturates at 2^LEN_W-1.
- R5: `status_o[1]` (runt) is set when the length is below 64.
- R6: `status_o[2]` (extra data) is set when the length exceeds 1518.
- R7: `status_o[0]` (CRC error) is set when the CRC-32 over all frame bytes, including the check sequence, fails to leave the good-frame residue.
- R8: Carrier is first sampled low in a frame on some clock edge. `done_o` goes high for one cycle right after that edge, with `len_o` and `status_o` valid. A byte flagged valid while carrier is low is dropped.
- R9: `status_o[3]` is set when all six address bytes matched. `accept_o` is set only together with `done_o`, and only when `status_o[3]` is set and bits 2..0 are clear.
- R10: `sof_i` has no effect while a frame is being received.
- R11: After reset, `wr_en_o`, `done_o` and `accept_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| crs_i | input | 1 | Carrier sense |
| sof_i | input | 1 | Start-of-frame flag from the decoder |
| vld_i | input | 1 | Byte valid |
| byte_i | input | 8 | Received byte |
| station_addr_i | input | 48 | Programmed individual address |
| wr_en_o | output | 1 | Buffer write strobe |
| wr_data_o | output | 8 | Buffer write byte |
| done_o | output | 1 | End-of-frame strobe |
| accept_o | output | 1 | Frame accepted, with `done_o` |
| len_o | output | 11 | Frame length at end of frame |
| status_o | output | 4 | {addr_hit, extra, runt, crc_err} |

## Verification
End-of-frame detection and byte intake can meet in one cycle: the last check-sequence byte is flagged valid in the same cycle that carrier drops. The bench provokes this directly. It expects the byte to be lost, so the reported length is one less, the CRC error bit is set, and no write is issued in the cycle of the end strobe. Random frames also put idle cycles and stray start flags into the data. Every written byte and every end strobe is compared against values the bench derives from the frame it built.

// File: rtl/rx_filter_pkg.sv
package rx_filter_pkg;
  localparam logic [7:0]  PRE_BYTE    = 8'h55;
  localparam logic [7:0]  SFD_BYTE    = 8'hD5;
  localparam logic [31:0] CRC_INIT    = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY    = 32'hEDB8_8320;
  // reflected-register form of the good-frame remainder
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB_20E3;

  typedef enum logic [1:0] {ST_IDLE, ST_HUNT, ST_DATA, ST_SKIP} rx_state_e;

  typedef struct packed {
    logic addr_hit;
    logic extra;
    logic runt;
    logic crc_err;
  } rx_status_t;

  function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/rx_sfd_detect.sv
module rx_sfd_detect
  import rx_filter_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       crs_i,
  input  logic       sof_i,
  input  logic       vld_i,
  input  logic [7:0] byte_i,
  output logic       start_o,
  output logic       take_o,
  output logic       eof_o
);
  rx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    start_o = 1'b0;
    take_o  = 1'b0;
    eof_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (crs_i && sof_i) begin
          if (vld_i && byte_i == SFD_BYTE) begin
            state_d = ST_DATA;
            start_o = 1'b1;
          end else if (vld_i && byte_i != PRE_BYTE) begin
            state_d = ST_SKIP;
          end else begin
            state_d = ST_HUNT;
          end
        end
      end
      ST_HUNT: begin
        if (!crs_i) begin
          state_d = ST_IDLE;
        end else if (vld_i) begin
          if (byte_i == SFD_BYTE) begin
            state_d = ST_DATA;
            start_o = 1'b1;
          end else if (byte_i != PRE_BYTE) begin
            state_d = ST_SKIP;
          end
        end
      end
      ST_DATA: begin
        if (!crs_i) begin
          state_d = ST_IDLE;
          eof_o   = 1'b1;
        end else begin
          take_o = vld_i;
        end
      end
      ST_SKIP: begin
        if (!crs_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  a_r8_eof_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !eof_o);
  a_r1_start_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !take_o && !eof_o);
endmodule

// File: rtl/rx_crc32.sv
module rx_crc32
  import rx_filter_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [7:0] byte_i,
  output logic       ok_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_INIT;
    else if (clr_i)  crc_q <= CRC_INIT;
    else if (en_i)   crc_q <= crc_step(crc_q, byte_i);
  end

  assign ok_o = (crc_q == CRC_RESIDUE);

  a_r7_clear_restores_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> crc_q == CRC_INIT);
endmodule

// File: rtl/rx_addr_len.sv
module rx_addr_len #(
  parameter int ADDR_W = 48,
  parameter int LEN_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [LEN_W-1:0]  len_o,
  output logic              match_o,
  output logic              wr_hit_o
);
  localparam int NB = ADDR_W / 8;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [LEN_W-1:0] NB_L    = LEN_W'(NB);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic [7:0]       addr_b [NB];
  logic [LEN_W-1:0] len_q;
  logic             match_q;
  logic             in_da, byte_ok;
  logic [IW-1:0]    idx;

  for (genvar g = 0; g < NB; g++) begin : g_addr
    assign addr_b[g] = addr_i[ADDR_W-1-8*g -: 8];
  end

  assign in_da    = (len_q < NB_L);
  assign idx      = len_q[IW-1:0];
  assign byte_ok  = !in_da || (byte_i == addr_b[idx]);
  assign wr_hit_o = match_q && byte_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q   <= '0;
      match_q <= 1'b1;
    end else if (clr_i) begin
      len_q   <= '0;
      match_q <= 1'b1;
    end else if (take_i) begin
      if (len_q != LEN_MAX) len_q <= len_q + 1'b1;
      match_q <= match_q && byte_ok;
    end
  end

  assign len_o   = len_q;
  assign match_o = match_q;

  a_r3_mismatch_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_q && !clr_i |=> !match_q);
  a_r4_len_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q == LEN_MAX && !clr_i |=> len_q == LEN_MAX);
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
  import rx_filter_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int LEN_W   = 11,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              crs_i,
  input  logic              sof_i,
  input  logic              vld_i,
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  output logic              wr_en_o,
  output logic [7:0]        wr_data_o,
  output logic              done_o,
  output logic              accept_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [3:0]        status_o
);
  localparam logic [LEN_W-1:0] NB_L  = LEN_W'(ADDR_W / 8);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

  logic             start, take, eof;
  logic             crc_ok, match, wr_hit;
  logic [LEN_W-1:0] len;
  rx_status_t       st_d;

  rx_sfd_detect i_sfd (
    .clk_i, .rst_ni, .crs_i, .sof_i, .vld_i, .byte_i,
    .start_o(start), .take_o(take), .eof_o(eof)
  );

  rx_crc32 i_crc (
    .clk_i, .rst_ni, .clr_i(start), .en_i(take), .byte_i, .ok_o(crc_ok)
  );

  rx_addr_len #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_addr_len (
    .clk_i, .rst_ni, .clr_i(start), .take_i(take), .byte_i,
    .addr_i(station_addr_i), .len_o(len), .match_o(match), .wr_hit_o(wr_hit)
  );

  always_comb begin
    st_d.crc_err  = !crc_ok;
    st_d.runt     = (len < MIN_L);
    st_d.extra    = (len > MAX_L);
    st_d.addr_hit = match && (len >= NB_L);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
      done_o    <= 1'b0;
      accept_o  <= 1'b0;
      len_o     <= '0;
      status_o  <= '0;
    end else begin
      wr_en_o   <= take && wr_hit;
      wr_data_o <= byte_i;
      done_o    <= eof;
      accept_o  <= eof && st_d.addr_hit && !st_d.crc_err && !st_d.runt && !st_d.extra;
      if (eof) begin
        len_o    <= len;
        status_o <= st_d;
      end
    end
  end

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_no_write_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && wr_en_o));
  a_r9_accept_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> done_o && status_o == 4'b1000 && len_o >= MIN_L && len_o <= MAX_L);
  a_r3_write_needs_carrier: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(crs_i && vld_i));
endmodule

// File: tb/test_rx_frame_filter.sv
module test_rx_frame_filter;
  localparam logic [47:0] STA = 48'h02_1A_2B_3C_4D_5E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        crs = 1'b0, sof = 1'b0, vld = 1'b0;
  logic [7:0]  bt = '0;
  logic        wr_en, done, accept;
  logic [7:0]  wr_data;
  logic [10:0] len;
  logic [3:0]  status;

  int n_chk = 0, n_fail = 0;
  logic [7:0] frm [0:2047];
  int rx_n, exp_wr, wr_cnt, done_cnt;
  bit exp_done, exp_crc, exp_hit;

  always #4 clk = ~clk;

  rx_frame_filter i_rx_frame_filter (
    .clk_i(clk), .rst_ni(rst_n), .crs_i(crs), .sof_i(sof), .vld_i(vld), .byte_i(bt),
    .station_addr_i(STA), .wr_en_o(wr_en), .wr_data_o(wr_data), .done_o(done),
    .accept_o(accept), .len_o(len), .status_o(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fcs_of(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++)
        c = (c[0] ^ frm[k][b]) ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    return ~c;
  endfunction

  // total bytes DA..FCS; bad_pos flips a DA byte (-1 none); corrupt breaks the payload
  task automatic build(input int total, input int bad_pos, input bit corrupt);
    logic [31:0] f;
    for (int k = 0; k < 6; k++) frm[k] = STA[47-8*k -: 8];
    if (bad_pos >= 0) frm[bad_pos] = frm[bad_pos] ^ 8'h81;
    for (int k = 6; k < total - 4; k++) frm[k] = 8'($urandom);
    f = fcs_of(total - 4);
    for (int k = 0; k < 4; k++) frm[total-4+k] = f[8*k +: 8];
    if (corrupt) frm[12] = frm[12] ^ 8'h10;
  endtask

  task automatic drive(input bit c, input bit s, input bit v, input logic [7:0] b);
    @(posedge clk); #1;
    crs = c; sof = s; vld = v; bt = b;
  endtask

  task automatic send(input int total, input int bad_pos, input bit corrupt,
                      input bit bad_pre, input bit collide, input bit noisy);
    build(total, bad_pos, corrupt);
    rx_n     = collide ? total - 1 : total;
    exp_done = !bad_pre;
    exp_crc  = corrupt || collide;
    exp_hit  = (bad_pos < 0) && rx_n >= 6;
    exp_wr   = bad_pre ? 0 : ((bad_pos >= 0 && bad_pos < rx_n) ? bad_pos : rx_n);
    wr_cnt   = 0;
    done_cnt = 0;
    drive(1, 1, 1, 8'h55);
    for (int k = 1; k < 7; k++) drive(1, 0, 1, (bad_pre && k == 3) ? 8'h5A : 8'h55);
    drive(1, 0, 1, 8'hD5);
    for (int k = 0; k < total; k++) begin
      if (noisy && ($urandom % 8) == 0) drive(1, ($urandom % 2) == 1, 0, 8'hD5);
      if (collide && k == total - 1) drive(0, 0, 1, frm[k]);
      else drive(1, noisy && (k % 37) == 5, 1, frm[k]);
    end
    for (int k = 0; k < 4; k++) drive(0, 0, 0, 8'h00);
    @(negedge clk);
    chk(done_cnt == int'(exp_done), "R8/R2 end strobe count", done_cnt, int'(exp_done));
    chk(wr_cnt == exp_wr, "R3/R1 written byte count", wr_cnt, exp_wr);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        chk(wr_cnt < rx_n && wr_data == frm[wr_cnt], "R3 write data",
            int'(wr_data), (wr_cnt < rx_n) ? int'(frm[wr_cnt]) : -1);
        wr_cnt++;
      end
      if (done) begin
        done_cnt++;
        chk(exp_done, "R2 unexpected end strobe", 1, 0);
        chk(int'(len) == rx_n, "R4 length", int'(len), rx_n);
        chk(status[0] == exp_crc, "R7 crc_err", int'(status[0]), int'(exp_crc));
        chk(status[1] == (rx_n < 64), "R5 runt", int'(status[1]), int'(rx_n < 64));
        chk(status[2] == (rx_n > 1518), "R6 extra", int'(status[2]), int'(rx_n > 1518));
        chk(status[3] == exp_hit, "R9 addr_hit", int'(status[3]), int'(exp_hit));
        chk(accept == (exp_hit && !exp_crc && rx_n >= 64 && rx_n <= 1518), "R9 accept",
            int'(accept), int'(exp_hit && !exp_crc && rx_n >= 64 && rx_n <= 1518));
      end else begin
        chk(!accept, "R9 accept without done", int'(accept), 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rx_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!wr_en && !done && !accept, "R11 reset outputs", int'({wr_en, done, accept}), 0);
    rst_n = 1'b1;
    send(100, -1, 0, 0, 0, 0);   // R1 clean accepted frame
    send(63,  -1, 0, 0, 0, 0);   // R5 runt edge
    send(64,  -1, 0, 0, 0, 0);   // R5 minimum length
    send(1518, -1, 0, 0, 0, 0);  // R6 maximum length
    send(1519, -1, 0, 0, 0, 0);  // R6 extra data
    send(80,  3, 0, 0, 0, 0);    // R3 address mismatch mid-address
    send(80,  0, 0, 0, 0, 0);    // R3 mismatch on first byte
    send(90,  -1, 1, 0, 0, 0);   // R7 corrupted payload
    send(90,  -1, 0, 1, 0, 0);   // R2 malformed preamble
    send(100, -1, 0, 0, 1, 0);   // R8 last byte collides with carrier drop
    send(120, -1, 0, 0, 0, 1);   // R10 stray sof and idle gaps
    for (int it = 0; it < 14; it++) begin
      int t  = 64 + int'($urandom % 300);
      int bp = (($urandom % 4) == 0) ? int'($urandom % 6) : -1;
      send(t, bp, ($urandom % 4) == 0, 0, ($urandom % 5) == 0, 1);
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule